// File: doc/BRIEF.md
# Serial Flash Register Write-Protect Controller

This block is the serial-bus front end that guards the status and configuration registers of a serial NOR flash. It watches the chip-select, serial clock, serial data-in and write-protect pins, decodes two commands (one arms a write-enable latch, the other loads new register values) and decides for each register load whether it is committed or refused. A load goes through only if the latch was armed by an earlier command and the register is not locked in hardware. The lock is active when the sticky write-disable bit is set and the write-protect pin is low.

All pins are brought into the system clock domain through synchronizers of equal depth. Serial data is taken on the rising serial-clock edge, serial mode 0, most significant bit first. A command takes effect only when chip-select returns high, and its effect depends on the exact number of bits shifted in. The register contents are presented on output ports, along with a protect flag that the array address check uses and an output-enable for the serial data-out pin.

Top module: `wrp_ctrl`

## Requirements
- R1: Bits are taken on each rising edge of `sck` while `cs_n` is low, most significant bit first: an 8-bit opcode, then a status byte, then a configuration byte. A command is evaluated when `cs_n` rises, and `cs_n` high clears the bit count.
- R2: After reset, `status_q` and `config_q` are 0x00 and `protect_o` is low.
- R3: Opcode 0x06 with exactly 8 bits sets the write-enable latch, which reads back as `status_q[1]`.
- R4: Opcode 0x01 (register load) is refused while the latch is clear: the write-disable bit, the block-protect field and `config_q` keep their values.
- R5: While the write-disable bit is 0, a register load with the latch set is committed at either level of `wp_n`.
- R6: While the write-disable bit is 1, a register load with the latch set is committed if `wp_n` is high and refused if `wp_n` is low. The lock forms whether the bit is set while the pin is low or the pin falls while the bit is set. Only raising `wp_n` releases it.
- R7: A committed load of 16 bits in total updates only the status fields. A committed load of 24 bits also loads `config_q`.
- R8: The latch is cleared after every register load of 8 or more bits, whether committed or refused.
- R9: A frame is aborted if it has fewer than 8 bits, if it carries opcode 0x06 with other than 8 bits, or if it carries opcode 0x01 with other than 16 or 24 bits. An aborted frame leaves the write-disable bit, the block-protect field and `config_q` unchanged and clears the latch.
- R10: `protect_o` is high exactly when the block-protect field is nonzero.
- R11: `so_oe` stays low at all times, so data-out stays high-impedance.
- R12: In the status byte that is loaded, bit 7 is the write-disable bit and bits 4:2 are the block-protect field. Bits 6, 5, 1 and 0 of that byte are ignored. `status_q` shows write-disable at bit 7, protect at bits 4:2, the latch at bit 1, and zeros elsewhere.
- R13: `wp_n` and `cs_n` pass through synchronizers of the same depth, so a `wp_n` change made in the same instant as the closing `cs_n` rise is honoured by that command.
- R14: A frame of 8 or more bits that carries any other opcode changes no state, including the latch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples all pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Serial chip-select, active low |
| sck | input | 1 | Serial clock |
| si | input | 1 | Serial data in |
| wp_n | input | 1 | Write-protect pin, active low |
| so_oe | output | 1 | Output enable for serial data out, always low |
| status_q | output | 8 | Status register: write-disable, block-protect, latch |
| config_q | output | 8 | Configuration register |
| protect_o | output | 1 | High when any block-protect bit is set |

## Verification
The frame-end decision and a change on the write-protect pin can reach the register logic in the same clock cycle, because both pins pass through synchronizers of equal depth. The bench provokes this by driving `wp_n` low in the same time step as the closing `cs_n` rise of an armed load while the write-disable bit is set. It judges the outcome from `status_q`: the load must be refused and the latch cleared. A second case sets the write-disable bit while the pin is already low and confirms that the next load is refused, so the lock forms in either order.

// File: rtl/wrp_pkg.sv
package wrp_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 5;
  localparam int BP_W   = 3;

  localparam logic [BYTE_W-1:0] OPC_ARM  = 8'h06;
  localparam logic [BYTE_W-1:0] OPC_LOAD = 8'h01;

  localparam logic [CNT_W-1:0] BITS_OPC  = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] BITS_STAT = CNT_W'(2 * BYTE_W);
  localparam logic [CNT_W-1:0] BITS_FULL = CNT_W'(3 * BYTE_W);

  typedef struct packed {
    logic            lock_bit;
    logic [BP_W-1:0] bp;
  } stat_fields_t;
endpackage

// File: rtl/wrp_sync.sv
module wrp_sync #(
  parameter int             W       = 1,
  parameter int             DEPTH   = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [DEPTH-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {DEPTH{RST_VAL[b]}};
      else        chain <= {chain[DEPTH-2:0], d[b]};
    end
    assign q[b] = chain[DEPTH-1];
  end
endmodule

// File: rtl/wrp_shift.sv
module wrp_shift
  import wrp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_q,
  input  logic              sck_q,
  input  logic              si_q,
  output logic              frame_done,
  output logic [CNT_W-1:0]  frame_bits,
  output logic [BYTE_W-1:0] opcode,
  output stat_fields_t      stat_in,
  output logic [BYTE_W-1:0] cfg_in
);
  logic              sck_d, cs_d;
  logic [CNT_W-1:0]  cnt, cnt_n;
  logic [BYTE_W-1:0] sh, sh_n, opc_n, cfg_n;
  logic [BYTE_W-1:0] byte_now;
  stat_fields_t      stat_n;
  logic              sck_rise;

  assign sck_rise = sck_q & ~sck_d & ~cs_q;
  assign byte_now = {sh[BYTE_W-2:0], si_q};

  always_comb begin
    cnt_n  = cnt;
    sh_n   = sh;
    opc_n  = opcode;
    stat_n = stat_in;
    cfg_n  = cfg_in;
    if (cs_q) begin
      cnt_n = '0;
    end else if (sck_rise) begin
      sh_n = byte_now;
      if (cnt != '1) cnt_n = cnt + 1'b1;
      if (cnt == BITS_OPC - 1'b1)  opc_n = byte_now;
      if (cnt == BITS_STAT - 1'b1) stat_n = '{lock_bit: byte_now[7], bp: byte_now[4:2]};
      if (cnt == BITS_FULL - 1'b1) cfg_n = byte_now;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_d   <= 1'b0;
      cs_d    <= 1'b1;
      cnt     <= '0;
      sh      <= '0;
      opcode  <= '0;
      stat_in <= '0;
      cfg_in  <= '0;
    end else begin
      sck_d   <= sck_q;
      cs_d    <= cs_q;
      cnt     <= cnt_n;
      sh      <= sh_n;
      opcode  <= opc_n;
      stat_in <= stat_n;
      cfg_in  <= cfg_n;
    end
  end

  assign frame_done = cs_q & ~cs_d;
  assign frame_bits = cnt;
endmodule

// File: rtl/wrp_regs.sv
module wrp_regs
  import wrp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_done,
  input  logic [CNT_W-1:0]  frame_bits,
  input  logic [BYTE_W-1:0] opcode,
  input  stat_fields_t      stat_in,
  input  logic [BYTE_W-1:0] cfg_in,
  input  logic              wp_q,
  output logic              lock_bit,
  output logic [BP_W-1:0]   bp,
  output logic              wel,
  output logic [BYTE_W-1:0] cfg
);
  logic              lock_n, wel_n;
  logic [BP_W-1:0]   bp_n;
  logic [BYTE_W-1:0] cfg_n;
  logic              full_opc, is_arm, is_load, len_stat, len_full, permit;

  assign full_opc = frame_bits >= BITS_OPC;
  assign is_arm   = full_opc && (opcode == OPC_ARM);
  assign is_load  = full_opc && (opcode == OPC_LOAD);
  assign len_stat = frame_bits == BITS_STAT;
  assign len_full = frame_bits == BITS_FULL;
  assign permit   = wel & ~(lock_bit & ~wp_q);

  always_comb begin
    lock_n = lock_bit;
    bp_n   = bp;
    wel_n  = wel;
    cfg_n  = cfg;
    if (frame_done) begin
      if (!full_opc) begin
        wel_n = 1'b0;
      end else if (is_arm) begin
        wel_n = (frame_bits == BITS_OPC);
      end else if (is_load) begin
        wel_n = 1'b0;
        if (permit && (len_stat || len_full)) begin
          lock_n = stat_in.lock_bit;
          bp_n   = stat_in.bp;
          if (len_full) cfg_n = cfg_in;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_bit <= 1'b0;
      bp       <= '0;
      wel      <= 1'b0;
      cfg      <= '0;
    end else if (frame_done) begin
      lock_bit <= lock_n;
      bp       <= bp_n;
      wel      <= wel_n;
      cfg      <= cfg_n;
    end
  end
endmodule

// File: rtl/wrp_ctrl.sv
module wrp_ctrl
  import wrp_pkg::*;
#(
  parameter int SYNC_DEPTH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sck,
  input  logic              si,
  input  logic              wp_n,
  output logic              so_oe,
  output logic [BYTE_W-1:0] status_q,
  output logic [BYTE_W-1:0] config_q,
  output logic              protect_o
);
  logic [1:0]        rst_pipe;
  logic              rst_sn;
  logic [3:0]        pins_q;
  logic              cs_q, sck_q, si_q, wp_q;
  logic              frame_done;
  logic [CNT_W-1:0]  frame_bits;
  logic [BYTE_W-1:0] opcode, cfg_in;
  stat_fields_t      stat_in;
  logic              lock_bit, wel;
  logic [BP_W-1:0]   bp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sn = rst_pipe[1];

  wrp_sync #(.W(4), .DEPTH(SYNC_DEPTH), .RST_VAL(4'b1001)) u_sync (
    .clk(clk), .rst_n(rst_sn), .d({cs_n, sck, si, wp_n}), .q(pins_q)
  );
  assign {cs_q, sck_q, si_q, wp_q} = pins_q;

  wrp_shift u_shift (
    .clk(clk), .rst_n(rst_sn), .cs_q(cs_q), .sck_q(sck_q), .si_q(si_q),
    .frame_done(frame_done), .frame_bits(frame_bits), .opcode(opcode),
    .stat_in(stat_in), .cfg_in(cfg_in)
  );

  wrp_regs u_regs (
    .clk(clk), .rst_n(rst_sn), .frame_done(frame_done), .frame_bits(frame_bits),
    .opcode(opcode), .stat_in(stat_in), .cfg_in(cfg_in), .wp_q(wp_q),
    .lock_bit(lock_bit), .bp(bp), .wel(wel), .cfg(config_q)
  );

  assign status_q  = {lock_bit, 2'b00, bp, wel, 1'b0};
  assign protect_o = |bp;
  assign so_oe     = 1'b0;
endmodule

// File: rtl/wrp_ctrl_chk.sv
module wrp_ctrl_chk
  import wrp_pkg::*;
(
  input logic              clk,
  input logic              rst_sn,
  input logic              frame_done,
  input logic [CNT_W-1:0]  frame_bits,
  input logic [BYTE_W-1:0] opcode,
  input logic              wp_q,
  input logic [BYTE_W-1:0] status_q,
  input logic [BYTE_W-1:0] config_q
);
  AST_ARM_SETS_LATCH: assert property (@(posedge clk) disable iff (!rst_sn)
    frame_done && frame_bits == BITS_OPC && opcode == OPC_ARM |=> status_q[1]); // R3

  AST_LOAD_CLEARS_LATCH: assert property (@(posedge clk) disable iff (!rst_sn)
    frame_done && frame_bits >= BITS_OPC && opcode == OPC_LOAD |=> !status_q[1]); // R8

  AST_NO_LATCH_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_sn)
    frame_done && !status_q[1] |=> $stable(status_q[7:2]) && $stable(config_q)); // R4

  AST_HW_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_sn)
    frame_done && status_q[7] && !wp_q |=> $stable(status_q[7:2]) && $stable(config_q)); // R6

  AST_SHORT_LOAD_KEEPS_CFG: assert property (@(posedge clk) disable iff (!rst_sn)
    frame_done && frame_bits == BITS_STAT |=> $stable(config_q)); // R7

  AST_ABORT_HOLDS: assert property (@(posedge clk) disable iff (!rst_sn)
    frame_done && frame_bits != BITS_STAT && frame_bits != BITS_FULL
    |=> $stable(status_q[7:2]) && $stable(config_q)); // R9
endmodule

bind wrp_ctrl wrp_ctrl_chk u_chk (
  .clk(clk), .rst_sn(rst_sn), .frame_done(frame_done), .frame_bits(frame_bits),
  .opcode(opcode), .wp_q(wp_q), .status_q(status_q), .config_q(config_q)
);

// File: tb/sim_wrp_ctrl.sv
module sim_wrp_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, si = 1'b0, wp_n = 1'b1;
  logic       so_oe, protect_o;
  logic [7:0] status_q, config_q;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  wrp_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si), .wp_n(wp_n),
    .so_oe(so_oe), .status_q(status_q), .config_q(config_q), .protect_o(protect_o)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // R1: mode 0, MSB first, evaluated on cs_n rise; wp_end is the wp_n level set with that rise
  task automatic frame(input logic [23:0] d, input int n, input logic wp_end);
    int oe_seen = 0;
    cs_n = 1'b0;
    wait_clk(8);
    for (int i = 0; i < n; i++) begin
      si = d[23-i];
      wait_clk(8);
      sck = 1'b1;
      if (so_oe !== 1'b0) oe_seen++;
      wait_clk(8);
      sck = 1'b0;
    end
    wait_clk(8);
    cs_n = 1'b1;
    wp_n = wp_end;
    wait_clk(12);
    check("R11 so_oe during frame", 8'(oe_seen), 8'd0);
  endtask

  task automatic arm();
    frame({8'h06, 16'h0}, 8, wp_n);
  endtask

  task automatic t_reset();
    check("R2 status", status_q, 8'h00);
    check("R2 config", config_q, 8'h00);
    check("R2 protect", {7'd0, protect_o}, 8'h00);
    check("R11 so_oe idle", {7'd0, so_oe}, 8'h00);
  endtask

  task automatic t_no_latch();
    frame({8'h01, 8'h9C, 8'h77}, 24, wp_n);
    check("R4 status unchanged", status_q, 8'h00);
    check("R4 config unchanged", config_q, 8'h00);
  endtask

  task automatic t_arm_and_unknown();
    arm();
    check("R3 latch set", status_q, 8'h02);
    frame({8'h9F, 16'h0}, 8, wp_n);
    check("R14 unknown opcode keeps latch", status_q, 8'h02);
  endtask

  task automatic t_full_load();
    wp_n = 1'b0;
    wait_clk(4);
    frame({8'h01, 8'h6F, 8'hA5}, 24, 1'b0);
    check("R5 R12 status loaded, latch cleared R8", status_q, 8'h0C);
    check("R7 config loaded", config_q, 8'hA5);
    check("R10 protect high", {7'd0, protect_o}, 8'h01);
  endtask

  task automatic t_status_only();
    wp_n = 1'b1;
    wait_clk(4);
    arm();
    frame({8'h01, 8'h84, 8'h00}, 16, 1'b1);
    check("R7 status only", status_q, 8'h84);
    check("R7 config kept", config_q, 8'hA5);
  endtask

  task automatic t_locked_then_release();
    wp_n = 1'b0;
    wait_clk(4);
    arm();
    check("R3 latch set under lock", status_q, 8'h86);
    frame({8'h01, 8'h00, 8'h11}, 24, 1'b0);
    check("R6 R8 locked refuse", status_q, 8'h84);
    check("R6 locked config", config_q, 8'hA5);
    wp_n = 1'b1;
    wait_clk(4);
    arm();
    frame({8'h01, 8'h80, 8'h3C}, 24, 1'b1);
    check("R6 released load", status_q, 8'h80);
    check("R6 released config", config_q, 8'h3C);
    check("R10 protect low", {7'd0, protect_o}, 8'h00);
  endtask

  task automatic t_aborts();
    arm();
    frame({8'h01, 8'h1C, 8'hFF}, 20, 1'b1);
    check("R9 load 20 bits", status_q, 8'h80);
    check("R9 config kept", config_q, 8'h3C);
    frame({8'h06, 8'h00, 8'h00}, 9, 1'b1);
    check("R9 arm 9 bits", status_q, 8'h80);
    arm();
    frame({8'h06, 16'h0}, 5, 1'b1);
    check("R9 short frame clears latch", status_q, 8'h80);
  endtask

  task automatic t_lock_order();
    arm();
    frame({8'h01, 8'h00, 8'h00}, 16, 1'b1);
    check("R6 clear bit", status_q, 8'h00);
    wp_n = 1'b0;
    wait_clk(4);
    arm();
    frame({8'h01, 8'h90, 8'h00}, 16, 1'b0);
    check("R5 load with wp low", status_q, 8'h90);
    arm();
    frame({8'h01, 8'h00, 8'h00}, 16, 1'b0);
    check("R6 set while low locks", status_q, 8'h90);
  endtask

  task automatic t_same_cycle();
    wp_n = 1'b1;
    wait_clk(4);
    arm();
    check("R13 armed", status_q, 8'h92);
    frame({8'h01, 8'h00, 8'h00}, 16, 1'b0);
    check("R13 wp fall with cs rise refuses", status_q, 8'h90);
    wp_n = 1'b1;
    wait_clk(4);
    arm();
    frame({8'h01, 8'h00, 8'h00}, 16, 1'b1);
    check("R13 release", status_q, 8'h00);
  endtask

  initial begin
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);
    t_reset();
    t_no_latch();
    t_arm_and_unknown();
    t_full_load();
    t_status_only();
    t_locked_then_release();
    t_aborts();
    t_lock_order();
    t_same_cycle();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule